// File: doc/BRIEF.md
# Tone Steering Guard-Time Validator

This block takes a raw tone-detect level, which is high while a dual-tone pair is currently being recognised, and turns it into a validated digit flag. The flag rises only after the tone has been present without interruption for an accept guard time. Once it is high, it falls only after the tone has been absent without interruption for a release guard time. Short dropouts inside a digit therefore leave the flag high, and short tone bursts never raise it.

Time is measured in ticks of a one-millisecond strobe that comes from elsewhere in the chip. The raw detect level may come from another clock domain, so it passes through a flip-flop synchronizer before any counting. A single-cycle pulse marks each newly accepted digit, and a powerdown input drops the flag at once.

Top module: `tone_guard_validator`

## Requirements
- R1: During and immediately after a synchronous reset, `digit_valid` and `digit_accept` are 0.
- R2: With `digit_valid` low, `digit_valid` rises on the clock edge that samples the ACC_MS-th `ms_tick` (default 30) counted while the synchronized detect level stays high. A tone lasting 40 ms is accepted.
- R3: A tone lasting 20 ms or less never raises `digit_valid` and never produces `digit_accept`.
- R4: With `digit_valid` high, `digit_valid` falls on the clock edge that samples the REL_MS-th `ms_tick` (default 30) counted while the synchronized detect level stays low. A 40 ms pause releases the flag.
- R5: A dropout of 20 ms or less inside a digit keeps `digit_valid` high and produces no second `digit_accept`.
- R6: Any return of the synchronized level to the state matching `digit_valid` before the threshold restarts the count from zero. For example, 25 ms on, 3 ms off and 25 ms on gives no acceptance.
- R7: `digit_accept` is high for exactly the one cycle in which `digit_valid` first reads 1 after being 0, and at no other time.
- R8: While `pwdn` is sampled high, the next cycle shows `digit_valid` = 0 and `digit_accept` = 0, and both guard counts are cleared.
- R9: Outside powerdown, `digit_valid` changes only on an edge that samples `ms_tick` high.
- R10: `tone_raw` reaches the counting logic through SYNC_STAGES (default 2) flip-flops, so counting uses the level sampled that many edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| pwdn | input | 1 | Powerdown; forces the flag low and clears the counts |
| tone_raw | input | 1 | Unsynchronized tone-present level |
| digit_valid | output | 1 | Validated digit flag |
| digit_accept | output | 1 | One-cycle pulse when a new digit is accepted |

## Verification
A completing guard tick and a powerdown request can arrive in the same cycle, and so can a completing tick and a detect level returning to its prior state. Random stimulus toggles the detect level with durations that spread around both thresholds and drops in short powerdown bursts at random. These collisions therefore occur many times. Every cycle, the outputs are compared against a bench model in which powerdown takes priority and a restored level cancels the pending transition.

// File: rtl/tgv_pkg.sv
package tgv_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_HELD = 1'b1
  } steer_state_t;
endpackage

// File: rtl/tgv_sync.sv
module tgv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tgv_run_counter.sv
module tgv_run_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == (limit - 1'b1));
  assign done    = tick && !clr && at_last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (at_last) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tone_guard_validator.sv
module tone_guard_validator #(
  parameter int ACC_MS      = 30,
  parameter int REL_MS      = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic pwdn,
  input  logic tone_raw,
  output logic digit_valid,
  output logic digit_accept
);
  import tgv_pkg::*;

  localparam int MAX_MS = (ACC_MS > REL_MS) ? ACC_MS : REL_MS;
  localparam int CW     = $clog2(MAX_MS + 1);
  localparam logic [CW-1:0] ACC_LIM = CW'(ACC_MS);
  localparam logic [CW-1:0] REL_LIM = CW'(REL_MS);

  steer_state_t  state_q;
  logic          tone_s;
  logic          opposing;
  logic [CW-1:0] limit;
  logic          expire;
  logic          accept_q;

  tgv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (tone_raw),
    .q   (tone_s)
  );

  // The count runs only while the synchronized level disagrees with the flag.
  assign opposing = (state_q == ST_HELD) ? !tone_s : tone_s;
  assign limit    = (state_q == ST_HELD) ? REL_LIM : ACC_LIM;

  tgv_run_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (pwdn || !opposing),
    .tick  (ms_tick),
    .limit (limit),
    .done  (expire)
  );

  always_ff @(posedge clk) begin
    if (rst || pwdn) begin
      state_q  <= ST_WAIT;
      accept_q <= 1'b0;
    end else begin
      accept_q <= expire && (state_q == ST_WAIT);
      if (expire) state_q <= (state_q == ST_WAIT) ? ST_HELD : ST_WAIT;
    end
  end

  assign digit_valid  = (state_q == ST_HELD);
  assign digit_accept = accept_q;
endmodule

// File: rtl/tgv_checker.sv
module tgv_checker (
  input logic clk,
  input logic rst,
  input logic ms_tick,
  input logic pwdn,
  input logic digit_valid,
  input logic digit_accept
);
  assert_accept_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    digit_accept |-> (digit_valid && !$past(digit_valid)));

  assert_rise_gives_accept_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(digit_valid) |-> digit_accept);

  assert_pwdn_forces_low_R8: assert property (@(posedge clk) disable iff (rst)
    $past(pwdn) |-> (!digit_valid && !digit_accept));

  assert_change_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(ms_tick) && !$past(pwdn)) |-> $stable(digit_valid));

  assert_rise_needs_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(digit_valid) |-> ($past(ms_tick) && !$past(pwdn)));
endmodule

bind tone_guard_validator tgv_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .ms_tick      (ms_tick),
  .pwdn         (pwdn),
  .digit_valid  (digit_valid),
  .digit_accept (digit_accept)
);

// File: tb/tone_guard_validator_tb.sv
module tone_guard_validator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_CYC   = 4;
  localparam int ACC        = 30;
  localparam int REL        = 30;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0;
  logic pwdn = 1'b0;
  logic tone_raw = 1'b0;
  logic digit_valid, digit_accept;

  int tests = 0;
  int fails = 0;
  int acc_cnt = 0;
  int cyc = 0;
  int div = 0;
  bit done = 0;

  tone_guard_validator #(.ACC_MS(ACC), .REL_MS(REL), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .pwdn(pwdn),
    .tone_raw(tone_raw), .digit_valid(digit_valid), .digit_accept(digit_accept)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Tick strobe driven away from the active edge.
  always @(negedge clk) begin
    div = (div == TICK_CYC-1) ? 0 : div + 1;
    ms_tick <= (div == TICK_CYC-1);
  end

  // Bench model built from R2, R4, R6, R8 and R10.
  logic m_s1 = 0, m_s2 = 0, m_st = 0, m_acc = 0;
  int   m_cnt = 0;
  function automatic int limit_for(input logic st);
    return st ? REL : ACC;
  endfunction
  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_st <= 0; m_acc <= 0; m_cnt <= 0;
    end else begin
      m_s1 <= tone_raw; m_s2 <= m_s1; m_acc <= 0;
      if (pwdn) begin
        m_st <= 0; m_cnt <= 0;
      end else if (m_s2 == m_st) begin
        m_cnt <= 0;
      end else if (ms_tick) begin
        if (m_cnt + 1 >= limit_for(m_st)) begin
          m_st <= !m_st; m_cnt <= 0; m_acc <= !m_st;
        end else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model (R10 latency, R2/R4/R6 counting, R7, R8).
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (digit_accept) acc_cnt++;
      if (digit_valid !== m_st)
        check(0, "R10 model digit_valid", int'(digit_valid), int'(m_st));
      if (digit_accept !== m_acc)
        check(0, "R7 model digit_accept", int'(digit_accept), int'(m_acc));
    end
    if (cyc > WATCHDOG && !done) begin
      fails++;
      done = 1;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic hold_ms(input logic lvl, input int ms);
    tone_raw = lvl;
    repeat (ms * TICK_CYC) @(negedge clk);
  endtask

  initial begin
    int a0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    check(digit_valid == 0, "R1 reset valid", digit_valid, 0);
    check(digit_accept == 0, "R1 reset accept", digit_accept, 0);
    rst = 0;
    hold_ms(0, 2);
    check(digit_valid == 0, "R1 after reset", digit_valid, 0);

    hold_ms(1, 40);
    check(digit_valid == 1, "R2 40ms tone accepted", digit_valid, 1);
    check(acc_cnt == 1, "R7 one accept pulse", acc_cnt, 1);

    hold_ms(0, 20);
    hold_ms(1, 10);
    check(digit_valid == 1, "R5 dropout bridged", digit_valid, 1);
    check(acc_cnt == 1, "R5 no second accept", acc_cnt, 1);

    hold_ms(0, 40);
    check(digit_valid == 0, "R4 40ms pause releases", digit_valid, 0);

    a0 = acc_cnt;
    hold_ms(1, 20);
    hold_ms(0, 10);
    check(digit_valid == 0, "R3 20ms tone rejected", digit_valid, 0);
    check(acc_cnt == a0, "R3 no accept", acc_cnt, a0);

    hold_ms(1, 25);
    hold_ms(0, 3);
    hold_ms(1, 25);
    check(digit_valid == 0, "R6 count restarted", digit_valid, 0);
    check(acc_cnt == a0, "R6 no accept", acc_cnt, a0);
    hold_ms(1, 10);
    check(digit_valid == 1, "R6 accepted after full run", digit_valid, 1);

    pwdn = 1;
    @(negedge clk);
    check(digit_valid == 0, "R8 pwdn forces low", digit_valid, 0);
    a0 = acc_cnt;
    hold_ms(1, 40);
    check(digit_valid == 0, "R8 held low in pwdn", digit_valid, 0);
    check(acc_cnt == a0, "R8 no accept in pwdn", acc_cnt, a0);
    pwdn = 0;
    hold_ms(1, 40);
    check(acc_cnt == a0 + 1, "R2 new accept after pwdn", acc_cnt, a0 + 1);
    hold_ms(0, 40);

    // Random segments around both thresholds, with powerdown bursts (R9, R10).
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 19) == 0) begin
        pwdn = 1;
        repeat ($urandom_range(1, 12)) @(negedge clk);
        pwdn = 0;
      end
      tone_raw = $urandom_range(0, 1);
      repeat ($urandom_range(1, 45) * TICK_CYC + $urandom_range(0, 3)) @(negedge clk);
    end
    check(1, "R9 random run complete", 1, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule